// File: doc/BRIEF.md
# Aspect-Configurable Dual-Clock Block RAM

This block is a 4096-bit on-chip memory with a write port and a read port. Each port has its own clock, clock enable and access enable. The storage is a fixed array of 256 words of 16 bits. A compile-time parameter chooses the logical shape the ports present: 2048x2, 1024x4, 512x8 or 256x16. In the narrow shapes, the low eight address bits pick a physical word and the next address bits pick a lane of that word.

The ports always have the full native widths: 11-bit addresses, and 16-bit read data, write data and write mask. A logical word occupies the low bits of the data and mask buses. A per-bit mask lets a write change only some bits of a logical word. The contents can be preloaded from a parameter vector, so the block also serves as a ROM when the write enables are held low.

Top module: `bram_aspect`

## Requirements
- R1: While rst_ni is low, and after it rises until the first enabled read, rdata_o is zero.
- R2: The initial contents come from INIT_P, where logical address k holds INIT_P[k*LOG_W +: LOG_W].
- R3: At a rising wclk_i edge with wclke_i and we_i both high, the logical word at waddr_i takes the value of wdata_i in every bit whose mask bit is 0.
- R4: A wmask_i bit set to 1 leaves the matching bit of the addressed logical word unchanged.
- R5: If either wclke_i or we_i is low, no stored bit changes, whatever waddr_i and wdata_i carry.
- R6: At a rising rclk_i edge with rclke_i and re_i both high, rdata_o takes the contents of the logical word at raddr_i. In every other cycle rdata_o holds its value.
- R7: Address bits [7:0] select the physical word and bits [7+log2(16/LOG_W):8] select the lane. A write never changes the other lanes of the same word.
- R8: When a read and a write reach the same word on the same clock edge, the read returns the contents from before the write.
- R9: Only the low LOG_W bits of wdata_i and wmask_i have any effect. rdata_o bits above LOG_W read as zero. Address bits above the logical address width are ignored.
- R10: A LOG_W other than 2, 4, 8 or 16 stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk_i | input | 1 | Read clock |
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output register |
| rclke_i | input | 1 | Read clock enable |
| re_i | input | 1 | Read enable |
| raddr_i | input | 11 | Read address |
| rdata_o | output | 16 | Read data, logical word in the low bits |
| wclke_i | input | 1 | Write clock enable |
| we_i | input | 1 | Write enable |
| waddr_i | input | 11 | Write address |
| wdata_i | input | 16 | Write data, logical word in the low bits |
| wmask_i | input | 16 | Write mask, a 1 keeps the stored bit |

## Verification
The bench builds two instances from one clock. The first uses LOG_W=4 with a computed preload, so that preloaded values, lane selection, masking and unused upper data bits can all be checked on a narrow word. The second uses LOG_W=16 with a zero preload, which exercises the full-width mask and ignored upper address bits. A LOG_W=4 instance can reach lanes 1 to 3 and make writes share a word with other lanes. The wide instance shows that address bits 10:8 fold back onto the same word.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int PHYS_W = 16;
  localparam int PHYS_WORDS = 256;

  // legal logical width: power of two, >1, not wider than the physical word
  function automatic bit width_ok(input int w, input int dw);
    return (w > 1) && (w <= dw) && ((w & (w - 1)) == 0) && ((dw % w) == 0);
  endfunction
endpackage

// File: rtl/bram_addr_split.sv
module bram_addr_split #(
  parameter int ADDR_W  = 11,
  parameter int WORD_AW = 8,
  parameter int LANE_AW = 2,
  localparam int LANE_IW = (LANE_AW > 0) ? LANE_AW : 1,
  localparam int USED_AW = WORD_AW + LANE_AW
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [WORD_AW-1:0] word_o,
  output logic [LANE_IW-1:0] lane_o
);
  assign word_o = addr_i[WORD_AW-1:0];

  if (LANE_AW > 0) begin : g_lane
    assign lane_o = addr_i[WORD_AW +: LANE_AW];
  end else begin : g_no_lane
    assign lane_o = '0;
  end

  if (USED_AW < ADDR_W) begin : g_unused_hi
    logic unused_hi;
    assign unused_hi = ^addr_i[ADDR_W-1:USED_AW];
  end
endmodule

// File: rtl/bram_wr_pack.sv
module bram_wr_pack #(
  parameter int DATA_W = 16,
  parameter int LOG_W  = 4,
  localparam int LANES   = DATA_W / LOG_W,
  localparam int LANE_AW = $clog2(LANES),
  localparam int LANE_IW = (LANE_AW > 0) ? LANE_AW : 1
) (
  input  logic [LANE_IW-1:0] lane_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  wmask_i,
  output logic [DATA_W-1:0]  wd_o,
  output logic [DATA_W-1:0]  bit_en_o
);
  // logical word replicated into every lane; only the selected lane is enabled
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wd_o[l*LOG_W +: LOG_W]     = wdata_i[LOG_W-1:0];
    assign bit_en_o[l*LOG_W +: LOG_W] = (lane_i == LANE_IW'(l)) ? ~wmask_i[LOG_W-1:0] : '0;
  end

  if (LOG_W < DATA_W) begin : g_unused_hi
    logic unused_hi;
    assign unused_hi = ^{wdata_i[DATA_W-1:LOG_W], wmask_i[DATA_W-1:LOG_W]};
  end

  always_comb begin
    if (!$isunknown(bit_en_o))
      a_r7_single_lane: assert ($countones(bit_en_o) <= LOG_W);
  end
endmodule

// File: rtl/bram_core.sv
module bram_core #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 256,
  parameter int LOG_W  = 4,
  parameter logic [WORDS*DATA_W-1:0] INIT_P = '0,
  localparam int WORD_AW = $clog2(WORDS),
  localparam int LANES   = DATA_W / LOG_W
) (
  input  logic               wclk_i,
  input  logic               rclk_i,
  input  logic               rst_ni,
  input  logic               wen_i,
  input  logic [WORD_AW-1:0] widx_i,
  input  logic [DATA_W-1:0]  wd_i,
  input  logic [DATA_W-1:0]  bit_en_i,
  input  logic               ren_i,
  input  logic [WORD_AW-1:0] ridx_i,
  output logic [DATA_W-1:0]  rd_word_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  // logical address k = lane*WORDS + word
  initial begin
    for (int w = 0; w < WORDS; w++)
      for (int l = 0; l < LANES; l++)
        mem_q[w][l*LOG_W +: LOG_W] = INIT_P[(l*WORDS + w)*LOG_W +: LOG_W];
  end

  always_ff @(posedge wclk_i) begin
    if (wen_i) begin
      for (int b = 0; b < DATA_W; b++)
        if (bit_en_i[b]) mem_q[widx_i][b] <= wd_i[b];
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_word_o <= '0;
    else if (ren_i) rd_word_o <= mem_q[ridx_i];
  end

  a_r3_write_lands: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wen_i |=> ((mem_q[$past(widx_i)] ^ $past(wd_i)) & $past(bit_en_i)) == '0);

  a_r4_mask_keeps: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wen_i |=> ((mem_q[$past(widx_i)] ^ $past(mem_q[widx_i])) & ~$past(bit_en_i)) == '0);

  a_r5_no_write: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wen_i |=> mem_q[$past(widx_i)] == $past(mem_q[widx_i]));

  a_r8_read_old: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_i |=> rd_word_o == $past(mem_q[ridx_i]));

  a_r6_word_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ren_i |=> $stable(rd_word_o));
endmodule

// File: rtl/bram_rd_lane.sv
module bram_rd_lane #(
  parameter int DATA_W = 16,
  parameter int LOG_W  = 4,
  localparam int LANES   = DATA_W / LOG_W,
  localparam int LANE_AW = $clog2(LANES),
  localparam int LANE_IW = (LANE_AW > 0) ? LANE_AW : 1
) (
  input  logic               rclk_i,
  input  logic               rst_ni,
  input  logic               ren_i,
  input  logic [LANE_IW-1:0] lane_i,
  input  logic [DATA_W-1:0]  rd_word_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [LANE_IW-1:0] lane_q;
  logic [LOG_W-1:0]   sel;

  // lane travels with the read so output stays coherent while holding
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    lane_q <= '0;
    else if (ren_i) lane_q <= lane_i;
  end

  assign sel     = rd_word_i[lane_q*LOG_W +: LOG_W];
  assign rdata_o = DATA_W'(sel);

  a_r6_out_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ren_i |=> $stable(rdata_o));

  a_r1_reset_zero: assert property (@(posedge rclk_i)
    !rst_ni |-> rdata_o == '0);
endmodule

// File: rtl/bram_aspect.sv
module bram_aspect #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = bram_pkg::PHYS_W,
  parameter int WORDS  = bram_pkg::PHYS_WORDS,
  parameter int LOG_W  = 16,
  parameter logic [WORDS*DATA_W-1:0] INIT_P = '0,
  localparam int WORD_AW = $clog2(WORDS),
  localparam int LANES   = DATA_W / LOG_W,
  localparam int LANE_AW = $clog2(LANES),
  localparam int LANE_IW = (LANE_AW > 0) ? LANE_AW : 1
) (
  input  logic              rclk_i,
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              rclke_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wclke_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wmask_i
);
  if (!bram_pkg::width_ok(LOG_W, DATA_W)) begin : g_bad_width
    $error("bram_aspect: LOG_W must be 2, 4, 8 or 16 (R10)");
  end

  logic               wen, ren;
  logic [WORD_AW-1:0] widx, ridx;
  logic [LANE_IW-1:0] wlane, rlane;
  logic [DATA_W-1:0]  wd, bit_en, rd_word;

  assign wen = wclke_i & we_i;
  assign ren = rclke_i & re_i;

  bram_addr_split #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .LANE_AW(LANE_AW)) u_wsplit (
    .addr_i(waddr_i), .word_o(widx), .lane_o(wlane)
  );

  bram_addr_split #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .LANE_AW(LANE_AW)) u_rsplit (
    .addr_i(raddr_i), .word_o(ridx), .lane_o(rlane)
  );

  bram_wr_pack #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_pack (
    .lane_i(wlane), .wdata_i(wdata_i), .wmask_i(wmask_i),
    .wd_o(wd), .bit_en_o(bit_en)
  );

  bram_core #(.DATA_W(DATA_W), .WORDS(WORDS), .LOG_W(LOG_W), .INIT_P(INIT_P)) u_core (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
    .wen_i(wen), .widx_i(widx), .wd_i(wd), .bit_en_i(bit_en),
    .ren_i(ren), .ridx_i(ridx), .rd_word_o(rd_word)
  );

  bram_rd_lane #(.DATA_W(DATA_W), .LOG_W(LOG_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .ren_i(ren), .lane_i(rlane),
    .rd_word_i(rd_word), .rdata_o(rdata_o)
  );

  a_r9_hi_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rdata_o >> LOG_W) == '0);
endmodule

// File: tb/tb_bram_aspect.sv
module tb_bram_aspect;
  localparam int NV = 13;

  // preload for the 4-bit instance: word k = k[3:0] ^ k[9:8]
  function automatic logic [4095:0] mk_init();
    logic [4095:0] v;
    v = '0;
    for (int k = 0; k < 1024; k++) begin
      logic [9:0] a;
      a = 10'(k);
      v[k*4 +: 4] = a[3:0] ^ {2'b00, a[9:8]};
    end
    return v;
  endfunction
  localparam logic [4095:0] INIT_TB = mk_init();

  // {write, addr[9:0], data[3:0], mask[3:0], expected[3:0]}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 10'h005, 4'h0, 4'h0, 4'h5},
    {1'b0, 10'h105, 4'h0, 4'h0, 4'h4},
    {1'b0, 10'h305, 4'h0, 4'h0, 4'h6},
    {1'b1, 10'h105, 4'hA, 4'h0, 4'h0},
    {1'b0, 10'h105, 4'h0, 4'h0, 4'hA},
    {1'b0, 10'h005, 4'h0, 4'h0, 4'h5},
    {1'b0, 10'h205, 4'h0, 4'h0, 4'h7},
    {1'b1, 10'h205, 4'h8, 4'h3, 4'h0},
    {1'b0, 10'h205, 4'h0, 4'h0, 4'hB},
    {1'b1, 10'h3FF, 4'h0, 4'hF, 4'h0},
    {1'b0, 10'h3FF, 4'h0, 4'h0, 4'hC},
    {1'b1, 10'h3FF, 4'h1, 4'h0, 4'h0},
    {1'b0, 10'h3FF, 4'h0, 4'h0, 4'h1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        rce_a = 0, re_a = 0, wce_a = 0, we_a = 0;
  logic [10:0] ra_a = '0, wa_a = '0;
  logic [15:0] wd_a = '0, wm_a = '0, rd_a;
  logic        rce_b = 0, re_b = 0, wce_b = 0, we_b = 0;
  logic [10:0] ra_b = '0, wa_b = '0;
  logic [15:0] wd_b = '0, wm_b = '0, rd_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bram_aspect #(.LOG_W(4), .INIT_P(INIT_TB)) dut (
    .rclk_i(clk), .wclk_i(clk), .rst_ni(rst_ni),
    .rclke_i(rce_a), .re_i(re_a), .raddr_i(ra_a), .rdata_o(rd_a),
    .wclke_i(wce_a), .we_i(we_a), .waddr_i(wa_a), .wdata_i(wd_a), .wmask_i(wm_a)
  );

  bram_aspect #(.LOG_W(16)) dut_w16 (
    .rclk_i(clk), .wclk_i(clk), .rst_ni(rst_ni),
    .rclke_i(rce_b), .re_i(re_b), .raddr_i(ra_b), .rdata_o(rd_b),
    .wclke_i(wce_b), .we_i(we_b), .waddr_i(wa_b), .wdata_i(wd_b), .wmask_i(wm_b)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [10:0] a, input logic [15:0] d, input logic [15:0] m,
                      input logic ce, input logic en);
    @(negedge clk);
    wa_a = a; wd_a = d; wm_a = m; wce_a = ce; we_a = en;
    @(negedge clk);
    wce_a = 0; we_a = 0;
  endtask

  task automatic rd_a_op(input logic [10:0] a);
    @(negedge clk);
    ra_a = a; rce_a = 1; re_a = 1;
    @(negedge clk);
    rce_a = 0; re_a = 0;
  endtask

  task automatic wr_b(input logic [10:0] a, input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    wa_b = a; wd_b = d; wm_b = m; wce_b = 1; we_b = 1;
    @(negedge clk);
    wce_b = 0; we_b = 0;
  endtask

  task automatic rd_b_op(input logic [10:0] a);
    @(negedge clk);
    ra_b = a; rce_b = 1; re_b = 1;
    @(negedge clk);
    rce_b = 0; re_b = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset a", rd_a, 16'h0);
    check("R1 reset b", rd_b, 16'h0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 after reset", rd_a, 16'h0);

    // table: R2 preload, R3 write, R4 mask, R7 lanes, R9 upper bits ignored
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        wr_a({1'b0, VEC[i][21:12]}, {12'hABC, VEC[i][11:8]}, {12'h5A5, VEC[i][7:4]}, 1, 1);
      end else begin
        rd_a_op({1'b0, VEC[i][21:12]});
        check("R2 R3 R4 R7 R9 table", rd_a, {12'h000, VEC[i][3:0]});
      end
    end

    // R5: one enable low, no change
    wr_a(11'h005, 16'h0009, 16'h0000, 0, 1);
    wr_a(11'h005, 16'h0009, 16'h0000, 1, 0);
    rd_a_op(11'h005);
    check("R5 no write", rd_a, 16'h0005);

    // R6: output holds unless both read enables high
    @(negedge clk);
    ra_a = 11'h105; rce_a = 0; re_a = 1;
    @(negedge clk);
    check("R6 hold rce low", rd_a, 16'h0005);
    rce_a = 1; re_a = 0;
    @(negedge clk);
    check("R6 hold re low", rd_a, 16'h0005);
    rce_a = 0;
    rd_a_op(11'h105);
    check("R6 read", rd_a, 16'h000A);

    // R8: same word same edge returns old data
    @(negedge clk);
    wa_a = 11'h105; wd_a = 16'h0003; wm_a = 16'h0; wce_a = 1; we_a = 1;
    ra_a = 11'h105; rce_a = 1; re_a = 1;
    @(negedge clk);
    wce_a = 0; we_a = 0; rce_a = 0; re_a = 0;
    check("R8 old data", rd_a, 16'h000A);
    rd_a_op(11'h105);
    check("R8 new data", rd_a, 16'h0003);
    rd_a_op(11'h305);
    check("R7 other lane", rd_a, 16'h0006);

    // wide instance: R3 R4 R9
    wr_b(11'h0AB, 16'h1234, 16'h0000);
    rd_b_op(11'h0AB);
    check("R3 wide write", rd_b, 16'h1234);
    wr_b(11'h7AB, 16'hFFFF, 16'hFF00);
    rd_b_op(11'h3AB);
    check("R4 R9 wide mask alias", rd_b, 16'h12FF);
    rd_b_op(11'h0AC);
    check("R2 wide zero preload", rd_b, 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule